// File: doc/BRIEF.md
# AXI4-Lite Load/Store Unit

This unit executes the data-memory half of 32-bit integer loads and stores on behalf of a CPU pipeline stage. The stage presents one request (direction, access kind, byte address and store data) while the unit signals that it is idle. The unit then runs one AXI4-Lite transaction as a master and reports completion with a single-cycle done pulse. Each transaction passes through three states: submit, await and success. For loads, the returned value is already aligned and extended.

Sub-word stores never read memory first. The unit places the byte or halfword into the correct lanes and asserts only the write strobes of those lanes. The bus address is always word aligned. The low two address bits only select lanes. Misaligned accesses raise no error. Response codes on the write-response and read-data channels are not examined, so every completed handshake counts as a success.

Top module: `axil_lsu`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1 and every AXI valid/ready output and both done pulses are 0.
- R2: A store accepted while `req_ready` is 1 raises `m_awvalid` and `m_wvalid` on the next cycle. Each stays high until its own handshake, and the two may complete in different cycles. `m_bready` rises only once both have completed. `st_done` is high for exactly the one cycle after the write-response handshake, and `req_ready` returns on the cycle after that.
- R3: An accepted load raises `m_arvalid` on the next cycle and holds it until `m_arready`. It then raises `m_rready`. `ld_done` is high for exactly the one cycle after the read-data handshake, with `ld_data` valid in that cycle. `ld_data` keeps its value until the next load completes.
- R4: `m_awaddr` and `m_araddr` equal the request address with bits [1:0] cleared.
- R5: `req_kind[1:0]` selects the access size: 00 is byte, 01 is halfword, and 10 or 11 is word. `req_kind[2]`=1 selects zero extension for sub-word loads (the RV32I funct3 encoding).
- R6: The store strobe for a byte is 1 shifted left by address[1:0]. For a halfword it is 4'b0011 when address[1] is 0 and 4'b1100 when it is 1. For a word it is 4'b1111.
- R7: Store data is laid into the lanes as follows: a byte is copied into all four byte lanes, a halfword into both halfword lanes, and a word is sent unchanged.
- R8: A byte load returns read-data byte number address[1:0]. It is sign-extended when `req_kind[2]`=0 and zero-extended otherwise.
- R9: A halfword load returns read-data bits [31:16] when address[1] is 1 and bits [15:0] otherwise, extended as in R8. Address bit 0 is ignored.
- R10: A word load returns the read word unchanged for every address[1:0], with no error.
- R11: A non-zero `m_bresp` or `m_rresp` has no effect: the transaction completes with the same timing and data.
- R12: `req_valid` is ignored while `req_ready` is 0: no further transaction starts.
- R13: A store never drives `m_arvalid`, so no read is made for a sub-word store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe from the pipeline |
| req_ready | output | 1 | Unit idle; a request is taken this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_kind | input | 3 | Size and extension code (R5) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data, right-justified |
| ld_data | output | DATA_W | Aligned, extended load result |
| ld_done | output | 1 | One-cycle load completion pulse |
| st_done | output | 1 | One-cycle store completion pulse |
| m_awaddr | output | ADDR_W | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code (ignored) |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code (ignored) |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
Stores are swept over every size and every byte offset. The slave accepts the address and data channels after different delays, which tells apart a unit that waits for both handshakes from one that moves on after the first. Loads are swept over all eight kind codes and all four offsets against two read words with opposite top bits in every byte. This separates sign extension from zero extension and lane selection from misaligned pass-through. Further runs return error response codes and raise a request while the unit is busy, to show that neither changes what happens at the ports.

// File: rtl/axil_lsu_pkg.sv
package axil_lsu_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_SUBMIT,
      ST_WR_AWAIT,
      ST_WR_OK,
      ST_RD_SUBMIT,
      ST_RD_AWAIT,
      ST_RD_OK
   } state_e;

   // low two kind bits give the size; both word codes collapse to SZ_WORD
   function automatic size_e kind_to_size(input logic [1:0] k);
      if (k == 2'b00)      return SZ_BYTE;
      else if (k == 2'b01) return SZ_HALF;
      else                 return SZ_WORD;
   endfunction

endpackage

// File: rtl/axil_lsu_store_pack.sv
module axil_lsu_store_pack
   import axil_lsu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit REPLICATE = 1'b1,
   localparam int NLANES   = DATA_W / 8,
   localparam int OFF_W    = $clog2(NLANES)
) (
   input  size_e              size,
   input  logic [OFF_W-1:0]   off,
   input  logic [DATA_W-1:0]  data,
   output logic [DATA_W-1:0]  lanes,
   output logic [NLANES-1:0]  strb
);

   localparam int HALF_LANES = NLANES / 2;

   for (genvar i = 0; i < NLANES; i++) begin : g_lane
      localparam int HALF_IDX  = i / HALF_LANES;
      localparam int HALF_BYTE = i % 2;
      logic [7:0] src;
      logic       hit;

      always_comb begin
         if (size == SZ_BYTE) begin
            src = data[7:0];
            hit = (off == OFF_W'(i));
         end else if (size == SZ_HALF) begin
            src = data[8*HALF_BYTE +: 8];
            hit = (off[OFF_W-1] == 1'(HALF_IDX));
         end else begin
            src = data[8*i +: 8];
            hit = 1'b1;
         end
      end

      assign strb[i] = hit;

      if (REPLICATE) begin : g_rep
         assign lanes[8*i +: 8] = src;
      end else begin : g_zero
         assign lanes[8*i +: 8] = hit ? src : 8'h00;
      end
   end

endmodule

// File: rtl/axil_lsu_load_unpack.sv
module axil_lsu_load_unpack
   import axil_lsu_pkg::*;
#(
   parameter int DATA_W  = 32,
   localparam int NLANES = DATA_W / 8,
   localparam int OFF_W  = $clog2(NLANES)
) (
   input  size_e              size,
   input  logic               zext,
   input  logic [OFF_W-1:0]   off,
   input  logic [DATA_W-1:0]  word,
   output logic [DATA_W-1:0]  value
);

   logic [7:0]  byte_v;
   logic [15:0] half_v;
   logic        fill;

   always_comb begin
      byte_v = word[{off, 3'b000} +: 8];
      half_v = word[{off[OFF_W-1], 4'b0000} +: 16];
      if (size == SZ_BYTE) begin
         fill  = ~zext & byte_v[7];
         value = {{(DATA_W-8){fill}}, byte_v};
      end else if (size == SZ_HALF) begin
         fill  = ~zext & half_v[15];
         value = {{(DATA_W-16){fill}}, half_v};
      end else begin
         fill  = 1'b0;
         value = word;
      end
   end

endmodule

// File: rtl/axil_lsu_ctrl.sv
module axil_lsu_ctrl
   import axil_lsu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic is_store,
   input  logic awready,
   input  logic wready,
   input  logic bvalid,
   input  logic arready,
   input  logic rvalid,
   output logic idle,
   output logic awvalid,
   output logic wvalid,
   output logic bready,
   output logic arvalid,
   output logic rready,
   output logic rd_capture,
   output logic rd_done,
   output logic wr_done
);

   state_e state;
   logic   aw_got, w_got;
   logic   aw_hs, w_hs;

   assign idle       = (state == ST_IDLE);
   assign awvalid    = (state == ST_WR_SUBMIT) && !aw_got;
   assign wvalid     = (state == ST_WR_SUBMIT) && !w_got;
   assign bready     = (state == ST_WR_AWAIT);
   assign arvalid    = (state == ST_RD_SUBMIT);
   assign rready     = (state == ST_RD_AWAIT);
   assign rd_capture = rready && rvalid;
   assign rd_done    = (state == ST_RD_OK);
   assign wr_done    = (state == ST_WR_OK);
   assign aw_hs      = awvalid && awready;
   assign w_hs       = wvalid && wready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         aw_got <= 1'b0;
         w_got  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               aw_got <= 1'b0;
               w_got  <= 1'b0;
               if (accept) state <= is_store ? ST_WR_SUBMIT : ST_RD_SUBMIT;
            end
            ST_WR_SUBMIT: begin
               aw_got <= aw_got | aw_hs;
               w_got  <= w_got | w_hs;
               if ((aw_got | aw_hs) && (w_got | w_hs)) state <= ST_WR_AWAIT;
            end
            ST_WR_AWAIT:  if (bvalid) state <= ST_WR_OK;
            ST_WR_OK:     state <= ST_IDLE;
            ST_RD_SUBMIT: if (arready) state <= ST_RD_AWAIT;
            ST_RD_AWAIT:  if (rvalid) state <= ST_RD_OK;
            ST_RD_OK:     state <= ST_IDLE;
            default:      state <= ST_IDLE;
         endcase
      end
   end

   // R2: address and data valids each held until accepted
   assert_aw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid && !awready |=> awvalid);
   assert_w_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wvalid && !wready |=> wvalid);
   // R2: completion follows a response handshake, lasts one cycle, then idle
   assert_wr_after_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_done) |-> $past(bvalid && bready));
   assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done && idle);
   // R3: read address held, done is a single cycle
   assert_ar_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      arvalid && !arready |=> arvalid);
   assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done && idle);
   // R13: no read channel activity while a store is in flight
   assert_no_read_on_store_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid || wvalid || bready) |-> !arvalid && !rready);

endmodule

// File: rtl/axil_lsu.sv
module axil_lsu
   import axil_lsu_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter bit REPLICATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_store,
   input  logic [2:0]           req_kind,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic [DATA_W-1:0]    ld_data,
   output logic                 ld_done,
   output logic                 st_done,
   output logic [ADDR_W-1:0]    m_awaddr,
   output logic                 m_awvalid,
   input  logic                 m_awready,
   output logic [DATA_W-1:0]    m_wdata,
   output logic [DATA_W/8-1:0]  m_wstrb,
   output logic                 m_wvalid,
   input  logic                 m_wready,
   input  logic [1:0]           m_bresp,
   input  logic                 m_bvalid,
   output logic                 m_bready,
   output logic [ADDR_W-1:0]    m_araddr,
   output logic                 m_arvalid,
   input  logic                 m_arready,
   input  logic [DATA_W-1:0]    m_rdata,
   input  logic [1:0]           m_rresp,
   input  logic                 m_rvalid,
   output logic                 m_rready
);

   localparam int NLANES = DATA_W / 8;
   localparam int OFF_W  = $clog2(NLANES);

   initial begin
      assert (DATA_W == 32) else $fatal(1, "axil_lsu: DATA_W must be 32");
      assert (ADDR_W > OFF_W) else $fatal(1, "axil_lsu: ADDR_W too small");
   end

   logic                accept;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   size_e               size_q;
   logic                zext_q;
   logic [OFF_W-1:0]    off_q;
   logic                rd_capture;
   logic [DATA_W-1:0]   ld_value;
   logic                resp_unused;

   assign resp_unused = ^{m_bresp, m_rresp};
   assign accept      = req_valid && req_ready;
   assign off_q       = addr_q[OFF_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         size_q  <= SZ_WORD;
         zext_q  <= 1'b0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         size_q  <= kind_to_size(req_kind[1:0]);
         zext_q  <= req_kind[2];
      end
   end

   assign m_awaddr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign m_araddr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   axil_lsu_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .is_store   (req_store),
      .awready    (m_awready),
      .wready     (m_wready),
      .bvalid     (m_bvalid),
      .arready    (m_arready),
      .rvalid     (m_rvalid),
      .idle       (req_ready),
      .awvalid    (m_awvalid),
      .wvalid     (m_wvalid),
      .bready     (m_bready),
      .arvalid    (m_arvalid),
      .rready     (m_rready),
      .rd_capture (rd_capture),
      .rd_done    (ld_done),
      .wr_done    (st_done)
   );

   axil_lsu_store_pack #(
      .DATA_W    (DATA_W),
      .REPLICATE (REPLICATE)
   ) u_pack (
      .size  (size_q),
      .off   (off_q),
      .data  (wdata_q),
      .lanes (m_wdata),
      .strb  (m_wstrb)
   );

   axil_lsu_load_unpack #(
      .DATA_W (DATA_W)
   ) u_unpack (
      .size  (size_q),
      .zext  (zext_q),
      .off   (off_q),
      .word  (m_rdata),
      .value (ld_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ld_data <= '0;
      else if (rd_capture) ld_data <= ld_value;
   end

   // R2: address and data held stable while waiting for the slave
   assert_awaddr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      m_awvalid && !m_awready |=> $stable(m_awaddr));
   assert_wdata_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      m_wvalid && !m_wready |=> $stable(m_wdata) && $stable(m_wstrb));
   // R6: a strobe pattern covers one, two or four lanes
   assert_strb_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      m_wvalid |-> ($countones(m_wstrb) == 1 || $countones(m_wstrb) == 2
                    || $countones(m_wstrb) == 4));
   // R3: result held after completion until the next read capture
   assert_ld_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done |=> $stable(ld_data));
   // R12: nothing starts while busy
   assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready && !m_awvalid && !m_wvalid && !m_arvalid |=> !$rose(m_arvalid) && !$rose(m_awvalid));

endmodule

// File: tb/tb_axil_lsu.sv
`timescale 1ns/1ps
module tb_axil_lsu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_store = 1'b0;
   logic [2:0]  req_kind = 3'b010;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] ld_data;
   logic        ld_done, st_done;
   logic [31:0] m_awaddr;
   logic        m_awvalid;
   logic        m_awready = 1'b0;
   logic [31:0] m_wdata;
   logic [3:0]  m_wstrb;
   logic        m_wvalid;
   logic        m_wready = 1'b0;
   logic [1:0]  m_bresp = 2'b00;
   logic        m_bvalid = 1'b0;
   logic        m_bready;
   logic [31:0] m_araddr;
   logic        m_arvalid;
   logic        m_arready = 1'b0;
   logic [31:0] m_rdata = '0;
   logic [1:0]  m_rresp = 2'b00;
   logic        m_rvalid = 1'b0;
   logic        m_rready;

   int n_chk = 0;
   int n_fail = 0;
   bit seq_ok;
   bit read_in_store = 1'b0;
   logic [31:0] got_awaddr, got_wdata, got_araddr, got_ld;
   logic [3:0]  got_wstrb;

   always #2 clk = ~clk;

   axil_lsu dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
      .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
      .ld_data(ld_data), .ld_done(ld_done), .st_done(st_done),
      .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
      .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
      .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
      .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
      .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_strb(input logic [2:0] k, input int off);
      if (k[1:0] == 2'b00) return 4'(1 << off);
      if (k[1:0] == 2'b01) return (off >= 2) ? 4'b1100 : 4'b0011;
      return 4'b1111;
   endfunction

   function automatic logic [31:0] exp_wdata(input logic [2:0] k, input logic [31:0] d);
      if (k[1:0] == 2'b00) return {4{d[7:0]}};
      if (k[1:0] == 2'b01) return {2{d[15:0]}};
      return d;
   endfunction

   function automatic logic [31:0] exp_load(input logic [2:0] k, input int off, input logic [31:0] w);
      logic [31:0] b, h;
      b = (w >> (8 * off)) & 32'hFF;
      h = (w >> (16 * (off / 2))) & 32'hFFFF;
      if (k[1:0] == 2'b00) return (!k[2] && b[7]) ? (b | 32'hFFFF_FF00) : b;
      if (k[1:0] == 2'b01) return (!k[2] && h[15]) ? (h | 32'hFFFF_0000) : h;
      return w;
   endfunction

   function automatic string load_tag(input logic [2:0] k);
      if (k[1:0] == 2'b00) return "R8 byte load";
      if (k[1:0] == 2'b01) return "R9 half load";
      if (k == 3'b010)     return "R10 word load";
      return "R5 word code load";
   endfunction

   task automatic do_store(input logic [2:0] k, input logic [31:0] addr, input logic [31:0] data,
                           input int awd, input int wd, input int bd, input logic [1:0] resp,
                           input bit poke);
      bit aw_seen, w_seen, hs_aw, hs_w;
      int cyc;
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b1; req_kind = k; req_addr = addr; req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0;
      seq_ok = 1'b1; aw_seen = 1'b0; w_seen = 1'b0; cyc = 0;
      while (!(aw_seen && w_seen) && cyc < 64) begin
         if (!aw_seen && !m_awvalid) seq_ok = 1'b0;
         if (!w_seen && !m_wvalid) seq_ok = 1'b0;
         if ((aw_seen && m_awvalid) || (w_seen && m_wvalid)) seq_ok = 1'b0;
         if (m_bready || st_done || req_ready) seq_ok = 1'b0;
         if (m_arvalid) read_in_store = 1'b1;
         m_awready = !aw_seen && cyc >= awd;
         m_wready  = !w_seen && cyc >= wd;
         hs_aw = m_awvalid && m_awready;
         hs_w  = m_wvalid && m_wready;
         if (hs_aw) got_awaddr = m_awaddr;
         if (hs_w) begin got_wdata = m_wdata; got_wstrb = m_wstrb; end
         @(negedge clk);
         cyc++;
         if (hs_aw) aw_seen = 1'b1;
         if (hs_w) w_seen = 1'b1;
      end
      m_awready = 1'b0; m_wready = 1'b0;
      if (poke) begin req_valid = 1'b1; req_store = 1'b0; req_kind = 3'b010; end
      for (int i = 0; i < bd; i++) begin
         if (!m_bready || st_done || m_awvalid || m_wvalid) seq_ok = 1'b0;
         if (m_arvalid) read_in_store = 1'b1;
         @(negedge clk);
      end
      req_valid = 1'b0;
      m_bvalid = 1'b1; m_bresp = resp;
      if (!m_bready) seq_ok = 1'b0;
      @(negedge clk);
      m_bvalid = 1'b0; m_bresp = 2'b00;
      if (!st_done || req_ready || ld_done) seq_ok = 1'b0;
      @(negedge clk);
      if (st_done || !req_ready) seq_ok = 1'b0;
   endtask

   task automatic do_load(input logic [2:0] k, input logic [31:0] addr, input logic [31:0] word,
                          input int ard, input int rdl, input logic [1:0] resp);
      bit ar_seen, hs;
      int cyc;
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b0; req_kind = k; req_addr = addr; req_wdata = 32'hDEAD_BEEF;
      @(negedge clk);
      req_valid = 1'b0;
      seq_ok = 1'b1; ar_seen = 1'b0; cyc = 0;
      while (!ar_seen && cyc < 64) begin
         if (!m_arvalid || m_awvalid || m_wvalid || m_rready || ld_done) seq_ok = 1'b0;
         m_arready = cyc >= ard;
         hs = m_arvalid && m_arready;
         if (hs) got_araddr = m_araddr;
         @(negedge clk);
         cyc++;
         if (hs) ar_seen = 1'b1;
      end
      m_arready = 1'b0;
      for (int i = 0; i < rdl; i++) begin
         if (!m_rready || m_arvalid || ld_done) seq_ok = 1'b0;
         @(negedge clk);
      end
      m_rvalid = 1'b1; m_rdata = word; m_rresp = resp;
      if (!m_rready) seq_ok = 1'b0;
      @(negedge clk);
      m_rvalid = 1'b0; m_rdata = ~word; m_rresp = 2'b00;
      if (!ld_done || req_ready || st_done) seq_ok = 1'b0;
      got_ld = ld_data;
      @(negedge clk);
      if (ld_done || !req_ready || ld_data != got_ld) seq_ok = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] words [2];
      words[0] = 32'h80FF_7F01;
      words[1] = 32'h017E_80FE;

      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1, "R1 ready in reset", {31'b0, req_ready}, 32'd1);
      chk({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, ld_done, st_done} === 7'b0,
          "R1 outputs idle in reset",
          {25'b0, m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, ld_done, st_done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(req_ready === 1'b1 && !m_awvalid && !m_arvalid && !st_done && !ld_done,
          "R1 idle after reset", {31'b0, req_ready}, 32'd1);

      // store sweep: every size and offset, skewed channel delays
      for (int k = 0; k < 3; k++) begin
         for (int off = 0; off < 4; off++) begin
            logic [31:0] a, d;
            a = 32'h1000_0040 + 32'(k * 16) + 32'(off);
            d = 32'hA1B2_C3D4 ^ (32'h1111_1111 * k) ^ 32'(off * 32'h0101_0001);
            do_store(3'(k), a, d, (off + k) % 3, (2 * off + k + 1) % 3, off % 2, 2'b00, 1'b0);
            chk(seq_ok, "R2 store handshake sequence", {31'b0, seq_ok}, 32'd1);
            chk(got_awaddr == (a & ~32'h3), "R4 write address aligned", got_awaddr, a & ~32'h3);
            chk(got_wstrb == exp_strb(3'(k), off), "R6 write strobes",
                {28'b0, got_wstrb}, {28'b0, exp_strb(3'(k), off)});
            chk(got_wdata == exp_wdata(3'(k), d), "R7 write lanes", got_wdata, exp_wdata(3'(k), d));
         end
      end
      chk(!read_in_store, "R13 no read during store", {31'b0, read_in_store}, 32'd0);

      // load sweep: every kind code, offset and both patterns
      for (int k = 0; k < 8; k++) begin
         for (int off = 0; off < 4; off++) begin
            for (int w = 0; w < 2; w++) begin
               logic [31:0] a;
               a = 32'h2000_0100 + 32'(w * 8) + 32'(off);
               do_load(3'(k), a, words[w], (off + k) % 3, k % 3, 2'b00);
               chk(seq_ok, "R3 load handshake sequence", {31'b0, seq_ok}, 32'd1);
               chk(got_araddr == (a & ~32'h3), "R4 read address aligned", got_araddr, a & ~32'h3);
               chk(got_ld == exp_load(3'(k), off, words[w]), load_tag(3'(k)),
                   got_ld, exp_load(3'(k), off, words[w]));
            end
         end
      end

      // error responses ignored
      do_store(3'b001, 32'h3000_0003, 32'h0000_BEEF, 1, 0, 2, 2'b10, 1'b0);
      chk(seq_ok && got_wstrb == 4'b1100, "R11 store with error response",
          {27'b0, seq_ok, got_wstrb}, {27'b0, 1'b1, 4'b1100});
      do_load(3'b000, 32'h3000_0002, 32'h0085_0000, 0, 1, 2'b11);
      chk(seq_ok && got_ld == 32'hFFFF_FF85, "R11 load with error response", got_ld, 32'hFFFF_FF85);

      // request raised while busy is dropped
      do_store(3'b010, 32'h4000_0000, 32'h1234_5678, 0, 0, 3, 2'b00, 1'b1);
      chk(seq_ok, "R12 store completes despite busy request", {31'b0, seq_ok}, 32'd1);
      begin
         bit quiet;
         quiet = 1'b1;
         for (int i = 0; i < 3; i++) begin
            if (m_arvalid || m_awvalid || !req_ready) quiet = 1'b0;
            @(negedge clk);
         end
         chk(quiet, "R12 busy request ignored", {31'b0, quiet}, 32'd1);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule